// File: doc/BRIEF.md
# Masked Vector Compress/Expand Unit

This unit rearranges the elements of a vector register under a per-element select mask, one element per clock. In compress mode it walks the active elements of the source vector in ascending order and packs those whose mask bit is set into the destination, starting at element 0. The number of packed elements is returned as a new vector length. In expand mode it does the reverse. It takes source elements in order from element 0 and places each one at the position of the next set mask bit. Destination positions whose mask bit is clear are never written, so they keep what the destination held before.

The unit does not store the vectors itself. It drives an element-serial read port toward the source register array, which answers in the same cycle. It also drives an element-serial write port toward the destination array. A caller loads the operation, the vector length and the mask with a one-cycle start pulse, waits for the done pulse, and then reads the packed length.

Top module: `vec_compress_expand`

## Requirements
- R1: While reset is held low and in the first cycle after it, busy, done, src_rd_en and dst_wr_en are 0 and packed_len is 0.
- R2: With op = 0 (compress), the source elements whose mask bit is 1 are written to destination positions 0, 1, 2 and so on, in ascending source order. Mask bit i belongs to element i.
- R3: packed_len equals the number of set mask bits below the effective vector length. It is valid from the done cycle and holds until the next accepted start.
- R4: After a compress, destination positions at or above packed_len keep their previous contents.
- R5: With op = 1 (expand), the k-th source element, counted from element 0, is written to the position of the k-th set mask bit.
- R6: After an expand, destination positions whose mask bit is 0 keep their previous contents.
- R7: Mask bits at positions at or above the effective vector length have no effect on the destination or on packed_len.
- R8: One element is handled per cycle. done is 1 for one cycle, in the cycle that follows the L-th rising edge after the edge that accepts start, where L is the effective length. busy is 1 from acceptance until done.
- R9: A start pulse while busy is 1 is ignored. The running operation completes with its original operation, mask and length.
- R10: A requested length above NUM_ELEM is treated as NUM_ELEM. A length of 0 completes with no writes and packed_len 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when busy is 0) |
| op | input | 1 | 0 = compress, 1 = expand |
| vlen | input | LEN_W | Requested vector length |
| mask | input | NUM_ELEM | One select bit per element |
| src_rd_en | output | 1 | Source element read strobe |
| src_rd_idx | output | IDX_W | Source element index |
| src_rd_data | input | ELEM_W | Source element, valid in the same cycle |
| dst_wr_en | output | 1 | Destination element write strobe |
| dst_wr_idx | output | IDX_W | Destination element index |
| dst_wr_data | output | ELEM_W | Destination element value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| packed_len | output | LEN_W | Count of selected elements |

## Verification
The hardest case to reach is a second start that arrives while an operation is running, with a different operation, mask and length. If it were taken, it would silently corrupt the destination. The stimulus raises start in the middle of a long compress with inverted parameters. The bench then checks that the destination contents, packed_len and the done latency all match the original request. Lengths above the element count, a zero length, and mask bits beyond the length are also driven on purpose, so that the length limit is seen to gate every write.

// File: rtl/vce_pkg.sv
// Package: shared types for the compress/expand unit.
// Assumes: one-bit operation select, three-state sequencer.
package vce_pkg;
    typedef enum logic {
        OP_COMPRESS = 1'b0,
        OP_EXPAND   = 1'b1
    } vce_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vce_state_e;
endpackage

// File: rtl/vce_seq.sv
// Sequencer: accepts start, latches operation/mask/length (length clamped
// to NUM_ELEM), steps an element cursor once per cycle and pulses done.
// Assumes: start is ignored while running; a zero length goes straight to done.
module vce_seq
    import vce_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int LEN_W    = $clog2(NUM_ELEM + 1),
    parameter int IDX_W    = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                op,
    input  logic [LEN_W-1:0]    vlen,
    input  logic [NUM_ELEM-1:0] mask,
    output logic                accept,
    output logic                run,
    output logic                done,
    output logic [IDX_W-1:0]    cursor,
    output vce_op_e             op_q,
    output logic [NUM_ELEM-1:0] mask_q,
    output logic [LEN_W-1:0]    vlen_q
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(NUM_ELEM);

    vce_state_e       state;
    logic [LEN_W-1:0] vlen_eff;
    logic             last;

    // Clamp the requested length to the register size.
    always_comb vlen_eff = (vlen > MAX_LEN) ? MAX_LEN : vlen;

    // Start is taken whenever no operation is running.
    always_comb accept = start && (state != ST_RUN);

    // Final element of the current operation.
    always_comb last = (LEN_W'(cursor) == vlen_q - LEN_W'(1));

    // Status decode.
    always_comb begin
        run  = (state == ST_RUN);
        done = (state == ST_DONE);
    end

    // State, cursor and latched operation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cursor <= '0;
            op_q   <= OP_COMPRESS;
            mask_q <= '0;
            vlen_q <= '0;
        end else if (accept) begin
            op_q   <= vce_op_e'(op);
            mask_q <= mask;
            vlen_q <= vlen_eff;
            cursor <= '0;
            state  <= (vlen_eff == '0) ? ST_DONE : ST_RUN;
        end else begin
            case (state)
                ST_RUN: begin
                    if (last) state  <= ST_DONE;
                    else      cursor <= cursor + IDX_W'(1);
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: done lasts one cycle unless a fresh zero-length start re-enters it.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R8: the cursor stays inside the active length while running.
    assert_cursor_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (LEN_W'(cursor) < vlen_q));

    // R9: latched operation and mask do not change during a run.
    assert_hold_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(op_q) && $stable(mask_q) && $stable(vlen_q)));
endmodule

// File: rtl/vce_pack_cnt.sv
// Pack counter: counts selected elements seen so far in the current run.
// It serves as the compress write slot, the expand read slot and the final
// packed length. Assumes: clr and the latched length update on the same edge.
module vce_pack_cnt #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] vlen_q,
    output logic [LEN_W-1:0] cnt
);
    // Count set mask bits handled in the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + LEN_W'(1);
    end

    // R3: the count can never exceed the active length.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= vlen_q);

    // R3: the count advances by at most one per element.
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> ((cnt == $past(cnt)) || (cnt == $past(cnt) + LEN_W'(1))));
endmodule

// File: rtl/vce_route.sv
// Router: maps cursor and pack count onto the read and write ports by mode.
// Compress reads at the cursor and writes at the pack slot. Expand reads at
// the pack slot and writes at the cursor. Assumes the source answers in the same cycle.
module vce_route
    import vce_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int ELEM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sel,
    input  vce_op_e           op_q,
    input  logic [IDX_W-1:0]  cursor,
    input  logic [IDX_W-1:0]  slot,
    input  logic [ELEM_W-1:0] src_rd_data,
    output logic              src_rd_en,
    output logic [IDX_W-1:0]  src_rd_idx,
    output logic              dst_wr_en,
    output logic [IDX_W-1:0]  dst_wr_idx,
    output logic [ELEM_W-1:0] dst_wr_data
);
    // Steer indices and strobes according to the latched mode.
    always_comb begin
        dst_wr_en   = run && sel;
        dst_wr_data = src_rd_data;
        if (op_q == OP_COMPRESS) begin
            src_rd_en  = run;
            src_rd_idx = cursor;
            dst_wr_idx = slot;
        end else begin
            src_rd_en  = run && sel;
            src_rd_idx = slot;
            dst_wr_idx = cursor;
        end
    end

    // R2: compress never writes ahead of the element being read.
    assert_pack_behind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr_en && op_q == OP_COMPRESS) |-> (dst_wr_idx <= src_rd_idx));

    // R5: expand never reads ahead of the position being written.
    assert_expand_behind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_en && op_q == OP_EXPAND) |-> (src_rd_idx <= dst_wr_idx));
endmodule

// File: rtl/vec_compress_expand.sv
// Top: masked compress/expand over element-serial register ports.
// Assumes: the source array read is combinational, and the destination array
// keeps every element that is not written.
module vec_compress_expand
    import vce_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 16,
    parameter int LEN_W    = $clog2(NUM_ELEM + 1),
    parameter int IDX_W    = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                op,
    input  logic [LEN_W-1:0]    vlen,
    input  logic [NUM_ELEM-1:0] mask,
    output logic                src_rd_en,
    output logic [IDX_W-1:0]    src_rd_idx,
    input  logic [ELEM_W-1:0]   src_rd_data,
    output logic                dst_wr_en,
    output logic [IDX_W-1:0]    dst_wr_idx,
    output logic [ELEM_W-1:0]   dst_wr_data,
    output logic                busy,
    output logic                done,
    output logic [LEN_W-1:0]    packed_len
);
    logic                accept;
    logic                run;
    logic [IDX_W-1:0]    cursor;
    vce_op_e             op_q;
    logic [NUM_ELEM-1:0] mask_q;
    logic [LEN_W-1:0]    vlen_q;
    logic                sel;
    logic [LEN_W-1:0]    cnt;

    vce_seq #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
        .mask(mask), .accept(accept), .run(run), .done(done),
        .cursor(cursor), .op_q(op_q), .mask_q(mask_q), .vlen_q(vlen_q)
    );

    // Mask bit of the element under the cursor.
    always_comb sel = mask_q[cursor];

    vce_pack_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(run && sel),
        .vlen_q(vlen_q), .cnt(cnt)
    );

    vce_route #(.IDX_W(IDX_W), .ELEM_W(ELEM_W)) u_route (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .op_q(op_q),
        .cursor(cursor), .slot(cnt[IDX_W-1:0]), .src_rd_data(src_rd_data),
        .src_rd_en(src_rd_en), .src_rd_idx(src_rd_idx),
        .dst_wr_en(dst_wr_en), .dst_wr_idx(dst_wr_idx),
        .dst_wr_data(dst_wr_data)
    );

    // Drive status outputs.
    always_comb begin
        busy       = run;
        packed_len = cnt;
    end

    // R7: no write lands at or beyond the active length.
    assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> (LEN_W'(dst_wr_idx) < vlen_q));

    // R8: writes only happen while an operation runs.
    assert_wr_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> busy);

    // R1: nothing is pending in the first cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!busy && !done && !dst_wr_en && packed_len == '0));
endmodule

// File: tb/tb_vec_compress_expand.sv
`timescale 1ns/1ps
module tb_vec_compress_expand;
    localparam int N     = 8;
    localparam int EW    = 16;
    localparam int LEN_W = $clog2(N + 1);
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             op = 1'b0;
    logic [LEN_W-1:0] vlen = '0;
    logic [N-1:0]     mask = '0;
    logic             src_rd_en, dst_wr_en, busy, done;
    logic [IDX_W-1:0] src_rd_idx, dst_wr_idx;
    logic [EW-1:0]    src_rd_data, dst_wr_data;
    logic [LEN_W-1:0] packed_len;

    logic [EW-1:0] src_mem [N];
    logic [EW-1:0] dst_mem [N];
    logic          fill = 1'b0;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vec_compress_expand #(.NUM_ELEM(N), .ELEM_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
        .mask(mask), .src_rd_en(src_rd_en), .src_rd_idx(src_rd_idx),
        .src_rd_data(src_rd_data), .dst_wr_en(dst_wr_en),
        .dst_wr_idx(dst_wr_idx), .dst_wr_data(dst_wr_data),
        .busy(busy), .done(done), .packed_len(packed_len)
    );

    assign src_rd_data = src_mem[src_rd_idx];

    initial begin
        for (int i = 0; i < N; i++) src_mem[i] = EW'(16'hA000 + i * 16'h11);
    end

    // Destination register array model: prefill or capture DUT writes.
    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < N; i++) dst_mem[i] <= EW'(16'h5000 + i);
        end else if (dst_wr_en) begin
            dst_mem[dst_wr_idx] <= dst_wr_data;
        end
    end

    task automatic check(input string rq, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Run one operation; optionally inject a second start mid-run.
    task automatic run_case(input string rq_data, input logic op_i,
                            input int vl, input logic [N-1:0] m, input bit inject);
        logic [EW-1:0] expd [N];
        int eff, k, lat;
        bit busy_ok;
        eff = (vl > N) ? N : vl;
        for (int i = 0; i < N; i++) expd[i] = EW'(16'h5000 + i);
        k = 0;
        for (int i = 0; i < eff; i++) begin
            if (m[i]) begin
                if (op_i == 1'b0) expd[k] = src_mem[i];
                else              expd[i] = src_mem[k];
                k++;
            end
        end
        @(negedge clk); fill = 1'b1;
        @(negedge clk); fill = 1'b0;
        start = 1'b1; op = op_i; vlen = LEN_W'(vl); mask = m;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        lat = 0; busy_ok = 1;
        while (!done && lat < 64) begin
            if (!busy) busy_ok = 0;
            if (inject && lat == 2) begin
                start = 1'b1; op = ~op_i; vlen = LEN_W'(2); mask = ~m;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check("R8", "done latency", lat, eff);
        check("R8", "busy while running", int'(busy_ok), 1);
        check("R3", "packed_len", int'(packed_len), k);
        @(negedge clk);
        for (int i = 0; i < N; i++) check(rq_data, $sformatf("dst[%0d]", i), int'(dst_mem[i]), int'(expd[i]));
        @(negedge clk);
        check("R3", "packed_len held", int'(packed_len), k);
        check("R8", "done single cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "wr_en in reset", int'(dst_wr_en), 0);
        check("R1", "rd_en in reset", int'(src_rd_en), 0);
        check("R1", "packed_len in reset", int'(packed_len), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_compress_basic();  run_case("R2/R4", 1'b0, 8, 8'b1011_0010, 0); endtask
    task automatic t_compress_dense();  run_case("R2/R4", 1'b0, 8, 8'hFF, 0);        endtask
    task automatic t_compress_none();   run_case("R2/R4", 1'b0, 8, 8'h00, 0);        endtask
    task automatic t_expand_basic();    run_case("R5/R6", 1'b1, 8, 8'b1011_0010, 0); endtask
    task automatic t_expand_alt();      run_case("R5/R6", 1'b1, 8, 8'b0101_0101, 0); endtask
    task automatic t_short_compress();  run_case("R7",    1'b0, 5, 8'hFF, 0);        endtask
    task automatic t_short_expand();    run_case("R7",    1'b1, 3, 8'hF6, 0);        endtask
    task automatic t_busy_start();      run_case("R9",    1'b0, 8, 8'h0F, 1);        endtask
    task automatic t_clamp();           run_case("R10",   1'b0, 12, 8'hFF, 0);       endtask
    task automatic t_zero_len();        run_case("R10",   1'b1, 0, 8'hFF, 0);        endtask

    initial begin
        repeat (40000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        t_reset();
        t_compress_basic();
        t_compress_dense();
        t_compress_none();
        t_expand_basic();
        t_expand_alt();
        t_short_compress();
        t_short_expand();
        t_busy_start();
        t_clamp();
        t_zero_len();
        report();
    end
endmodule